// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the addresses for a four-beat cache-line burst. When an access begins, a load strobe captures a full starting address. Each later rising edge with the advance strobe high moves the burst to its next position. Only the two lowest address bits change during a burst. The bits above them keep the value that was loaded. The address output is built from registered state, so it shows beat 0 in the cycle after the load.

A static mode strap picks the order of the beats. With the strap low the order is linear: the low bits count up from the start and wrap modulo four. With the strap high the order is interleaved: the beat number is XOR-ed into the starting low bits. A board leaves the strap tied high when interleaved order is wanted, and the strap is changed only while reset is asserted.

The sequencer has five named states:
- `ST_IDLE`: nothing loaded since reset.
- `ST_BEAT0` through `ST_BEAT3`: the current beat position.

It has four named transitions:
- *load*: any state goes to `ST_BEAT0`.
- *step*: `ST_BEATn` goes to `ST_BEATn+1` on advance.
- *wrap*: `ST_BEAT3` goes to `ST_BEAT0` on advance.
- *hold*: no strobe, or advance while in `ST_IDLE`, leaves the state unchanged.

Top module: `burst_addr_gen`

## Requirements
- R1: During and after reset, with no load yet, `addr_o` is all zeros and `last_o` is 0.
- R2: After a rising edge with `load_i` high, `addr_o` equals `start_i` as sampled at that edge. This is beat 0.
- R3: With `mode_i`=0, beat n has low bits `addr_o[1:0]` equal to (start[1:0] + n) mod 4.
- R4: With `mode_i`=1, beat n has low bits `addr_o[1:0]` equal to start[1:0] XOR n.
- R5: The beat number rises by one only at an edge where `advance_i` is high. With both strobes low, `addr_o` holds its value.
- R6: Bits `addr_o[ADDR_W-1:2]` equal the loaded value through the whole burst.
- R7: When `load_i` and `advance_i` are both high at one edge, the load wins and the burst restarts at beat 0 of the new start address.
- R8: `last_o` is 1 exactly while beat 3 (the fourth address) is presented.
- R9: An advance from beat 3 returns to beat 0, which is the starting address. Later advances keep cycling through the same four addresses.
- R10: Before the first load after reset, `advance_i` has no effect: `addr_o` stays zero and `last_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Order strap: 0 linear, 1 interleaved |
| load_i | input | 1 | Captures `start_i` and begins a burst |
| start_i | input | ADDR_W | Starting address of the burst |
| advance_i | input | 1 | Steps to the next burst position |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth beat |

## Verification
The two functions that can meet in one cycle are capturing a new start address and stepping the current burst. The bench raises both strobes on the same edge at several points: in the middle of a burst, on beat 3, and in both ordering modes. It expects the next address to be beat 0 of the new start with `last_o` low. A behavioural reference model with integer state predicts every cycle. A long seeded mix of loads and advances also produces many coincident strobes, and the model judges each of them.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } beat_state_t;

    function automatic logic [BEAT_W-1:0] beat_of(input beat_state_t s);
        logic [BEAT_W-1:0] b;
        unique case (s)
            ST_BEAT1: b = BEAT_W'(1);
            ST_BEAT2: b = BEAT_W'(2);
            ST_BEAT3: b = BEAT_W'(3);
            default:  b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              advance_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              active_o,
    output logic              last_o
);

    beat_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_BEAT0;
        end else if (advance_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat_o   = beat_of(state_q);
        active_o = (state_q != ST_IDLE);
        last_o   = (state_q == ST_BEAT3);
    end

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_q == ST_BEAT0)); // R7
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !load_i) |=> (state_q == ST_IDLE)); // R10
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BEAT3 && advance_i && !load_i) |=> (state_q == ST_BEAT0)); // R9
    AST_LAST_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(last_o) |-> ($past(advance_i) && !$past(load_i))); // R8

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    output logic [ADDR_W-1:0] start_o
);

    always_ff @(posedge clk) begin
        if (rst)         start_o <= '0;
        else if (load_i) start_o <= start_i;
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic              mode_i,
    input  logic [BEAT_W-1:0] start_lo_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] lo_o
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    always_comb begin
        lin_lo = start_lo_i + beat_i;
        ilv_lo = start_lo_i ^ beat_i;
        lo_o   = mode_i ? ilv_lo : lin_lo;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] lo_bits;
    logic              active;

    burst_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .advance_i (advance_i),
        .beat_o    (beat),
        .active_o  (active),
        .last_o    (last_o)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .start_o (start_q)
    );

    burst_order_map u_map (
        .mode_i     (mode_i),
        .start_lo_i (start_q[BEAT_W-1:0]),
        .beat_i     (beat),
        .lo_o       (lo_bits)
    );

    always_comb begin
        addr_o = {start_q[ADDR_W-1:BEAT_W], lo_bits};
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(start_i))); // R2
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !advance_i) |=> $stable(addr_o)); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |-> (addr_o == '0 && !last_o)); // R10

    initial begin
        assert (HI_W >= 1) else $error("address too narrow");
    end

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int AW = 20;

    logic          clk = 0;
    logic          rst;
    logic          mode_i;
    logic          load_i;
    logic [AW-1:0] start_i;
    logic          advance_i;
    logic [AW-1:0] addr_o;
    logic          last_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int        m_loaded;
    int        m_beat;
    bit [AW-1:0] m_base;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .load_i(load_i),
        .start_i(start_i), .advance_i(advance_i),
        .addr_o(addr_o), .last_o(last_o)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_loaded = 0; m_base = '0; m_beat = 0;
        end else if (load_i) begin
            m_loaded = 1; m_base = start_i; m_beat = 0;
        end else if (advance_i && m_loaded != 0) begin
            m_beat = (m_beat + 1) % 4;
        end
    end

    function automatic bit [AW-1:0] exp_addr();
        int lo;
        if (m_loaded == 0) return '0;
        if (mode_i) lo = int'(m_base[1:0]) ^ m_beat;
        else        lo = (int'(m_base[1:0]) + m_beat) % 4;
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic compare(input string tag);
        bit [AW-1:0] ea;
        bit          el;
        ea = exp_addr();
        el = (m_loaded != 0) && (m_beat == 3);
        checks++;
        if (addr_o !== ea || last_o !== el) begin
            errors++;
            if (last_o !== el)
                $display("FAIL R8 (%s): last_o=%0b expected %0b", tag, last_o, el);
            else
                $display("FAIL %s: addr_o=%h expected %h", tag, addr_o, ea);
        end
    endtask

    string prev_tag = "R1";

    task automatic step(input bit ld, input bit [AW-1:0] a, input bit av, input string tag);
        @(negedge clk);
        compare(prev_tag);
        load_i = ld; start_i = a; advance_i = av;
        prev_tag = tag;
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst = 1; mode_i = m; load_i = 0; advance_i = 0; start_i = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        prev_tag = "R1";
    endtask

    task automatic phase(input bit m);
        string ord;
        ord = m ? "R4" : "R3";
        do_reset(m);
        step(0, '0, 1, "R10");
        step(0, '0, 1, "R10");
        step(1, 20'hABCD6, 0, "R2");
        step(0, '0, 0, "R5");
        step(0, '0, 1, ord);
        step(0, '0, 0, "R5");
        step(0, '0, 1, ord);
        step(0, '0, 1, "R8");
        step(0, '0, 1, "R9");
        step(0, '0, 1, "R9");
        step(1, 20'h12347, 1, "R7");
        step(0, '0, 1, "R6");
        step(0, '0, 1, "R6");
        step(0, '0, 1, "R8");
        step(1, 20'hFFFF1, 1, "R7");
        step(0, '0, 0, "R2");
        for (int s = 0; s < 4; s++) begin
            step(1, AW'(20'h5A5A0 + s), 0, "R2");
            for (int k = 0; k < 6; k++) step(0, '0, 1, ord);
        end
        for (int i = 0; i < 400; i++) begin
            bit l, a;
            l = ($urandom % 6) == 0;
            a = ($urandom % 3) != 0;
            step(l, AW'($urandom), a, (l && a) ? "R7" : ord);
        end
        step(0, '0, 0, "R5");
    endtask

    initial begin
        rst = 1; mode_i = 0; load_i = 0; advance_i = 0; start_i = '0;
        m_loaded = 0; m_beat = 0; m_base = '0;
        repeat (2) @(negedge clk);
        compare("R1");
        phase(0);
        phase(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule